// File: doc/BRIEF.md
# Byte-Serial Wide Instruction Fetch

This unit feeds a three-slot wide-instruction pipeline from a narrow external program SRAM. The SRAM has 8 address lines and 8 data lines, so a 24-bit instruction word cannot arrive in one access. Each pipeline stage lasts three clock cycles. The unit performs one byte read in each of those cycles and joins the three bytes into one word. The word goes to the decoder together with a single-cycle valid strobe.

The read address changes on the rising clock edge. The returned byte is captured on the falling edge of the same cycle, which gives the external part half a cycle to respond. The unit keeps the byte address itself and advances it by one on every cycle. A redirect input names a target instruction index. The unit converts that index to a byte address (three bytes per instruction) and applies it only where one stage ends and the next begins, so a word that is partly fetched is always completed first. Reset clears the address and starts a fresh stage.

Top module: `vliw_byte_fetch`

## Requirements
- R1: While `rst_n` is low, `mem_addr` is 0, `instr_valid` is 0 and `instr_word` is 0. The first cycle after release begins a new stage and reads byte address 0.
- R2: One byte is read per cycle. On each rising edge, unless a redirect is applied, `mem_addr` becomes its previous value plus one, and the address after 255 is 0.
- R3: A stage is three consecutive cycles. Within a stage, the byte read in the first cycle goes to `instr_word[23:16]`, the byte from the second cycle to `[15:8]`, and the byte from the third cycle to `[7:0]`.
- R4: `instr_valid` is high for exactly one cycle, the cycle after the third read of a stage, and `instr_word` carries the new word in that cycle. At all other times `instr_word` holds its last value.
- R5: Each byte is sampled from `mem_data` on the falling clock edge in the middle of the cycle that presents its address. Values on `mem_data` during the second half of the cycle have no effect.
- R6: A redirect applies on the rising edge that ends a stage. At that edge `mem_addr` becomes (3 × `redirect_idx`) mod 256, and the word of the stage that is ending is still delivered in full.
- R7: A redirect that arrives in the first or second cycle of a stage is held until the stage ends and does not disturb the reads already under way. If several requests arrive before one boundary, the last index wins.
- R8: An instruction whose bytes straddle the top of the space (addresses 255, 0, 1) is assembled from those three bytes in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. The address is driven on the rising edge and data is sampled on the falling edge. |
| rst_n | input | 1 | Asynchronous active-low reset |
| redirect | input | 1 | Request to continue fetching at a new instruction index |
| redirect_idx | input | 7 | Target instruction index (byte address = 3 × index, mod 256) |
| mem_data | input | 8 | Byte returned by the external program memory |
| mem_addr | output | 8 | Byte address sent to the external program memory |
| instr_word | output | 24 | Assembled instruction word |
| instr_valid | output | 1 | Single-cycle strobe marking a new `instr_word` |

## Verification
If the stage slot counter is wrong, bytes land in the wrong lanes and the valid strobe appears on the wrong cycle. This shows up at the ports within one stage, three cycles. A wrong address counter is visible on `mem_addr` in the very next cycle, and a redirect that is lost or applied early shows as an unexpected address at or before the next stage boundary. A capture on the wrong clock edge is exposed because the bench model drives a corrupted byte after every falling edge, so the next delivered word is wrong.

// File: rtl/vliw_byte_fetch.sv
module vliw_byte_fetch #(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8,
  parameter int BYTES  = 3,
  parameter int IDX_W  = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      redirect,
  input  logic [IDX_W-1:0]          redirect_idx,
  input  logic [BYTE_W-1:0]         mem_data,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [BYTE_W*BYTES-1:0]   instr_word,
  output logic                      instr_valid
);
  localparam int WORD_W = BYTE_W * BYTES;
  localparam int SLOT_W = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(BYTES - 1);

  logic [SLOT_W-1:0] slot;
  logic [BYTE_W-1:0] cap_q;
  logic [WORD_W-1:0] acc;
  logic              pend_q;
  logic [IDX_W-1:0]  pidx_q;

  wire               at_end = (slot == LAST);
  wire               take   = redirect | pend_q;
  wire [IDX_W-1:0]   tidx   = redirect ? redirect_idx : pidx_q;
  wire [ADDR_W-1:0]  target = ADDR_W'(32'(tidx) * BYTES);
  wire [WORD_W-1:0]  acc_n  = {acc[WORD_W-BYTE_W-1:0], cap_q};

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) cap_q <= '0;
    else        cap_q <= mem_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      slot <= '0;
      mem_addr <= '0;
      acc <= '0;
      pend_q <= 1'b0;
      pidx_q <= '0;
      instr_word <= '0;
      instr_valid <= 1'b0;
    end else begin
      acc <= acc_n;
      instr_valid <= at_end;
      if (at_end) begin
        slot <= '0;
        instr_word <= acc_n;
        pend_q <= 1'b0;
        mem_addr <= take ? target : mem_addr + 1'b1;
      end else begin
        slot <= slot + 1'b1;
        mem_addr <= mem_addr + 1'b1;
        if (redirect) begin
          pend_q <= 1'b1;
          pidx_q <= redirect_idx;
        end
      end
    end
endmodule

// File: rtl/fetch_checker.sv
module fetch_checker #(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8,
  parameter int BYTES  = 3,
  parameter int IDX_W  = 7,
  parameter int SLOT_W = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    redirect,
  input logic [IDX_W-1:0]        redirect_idx,
  input logic [ADDR_W-1:0]       mem_addr,
  input logic [BYTE_W*BYTES-1:0] instr_word,
  input logic                    instr_valid,
  input logic [SLOT_W-1:0]       slot
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(BYTES - 1);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (mem_addr == '0 && !instr_valid && instr_word == '0));

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(slot) != LAST) |-> mem_addr == $past(mem_addr) + 1'b1);

  assert_slot_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= LAST);

  assert_valid_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && instr_valid) |-> ($past(slot) == LAST && slot == '0));

  assert_word_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !instr_valid) |-> $stable(instr_word));

  assert_redirect_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(slot) == LAST && $past(redirect))
      |-> mem_addr == ADDR_W'(32'($past(redirect_idx)) * BYTES));
endmodule

bind vliw_byte_fetch fetch_checker #(
  .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .BYTES(BYTES), .IDX_W(IDX_W), .SLOT_W(SLOT_W)
) chk (.*);

// File: tb/vliw_byte_fetch_test.sv
`timescale 1ns/1ps
module vliw_byte_fetch_test;
  logic clk = 0;
  logic rst_n = 0;
  logic redirect = 0;
  logic [6:0] redirect_idx = '0;
  logic [7:0] mem_data = '0;
  logic [7:0] mem_addr;
  logic [23:0] instr_word;
  logic instr_valid;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0] eaddr;
  int eslot;
  bit epend;
  logic [6:0] epidx;
  logic [23:0] ebuf, eword;
  bit ev;

  vliw_byte_fetch uut (.*);

  always #10 clk = ~clk;

  function automatic logic [7:0] mem_at(logic [7:0] a);
    return 8'((32'(a) * 37 + 11) ^ (32'(a) >> 3));
  endfunction

  initial forever begin
    @(posedge clk); #2 mem_data = mem_at(mem_addr);
    @(negedge clk); #2 mem_data = ~mem_at(mem_addr);
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    eaddr = 0; eslot = 0; epend = 0; epidx = 0; ebuf = 0; eword = 0; ev = 0;
  endtask

  task automatic tick(bit r, logic [6:0] idx, string atag);
    logic [7:0] b;
    redirect = r;
    redirect_idx = idx;
    b = mem_at(eaddr);
    @(posedge clk);
    ebuf = {ebuf[15:0], b};
    if (r) begin epend = 1; epidx = idx; end
    ev = (eslot == 2);
    if (ev) begin
      eword = ebuf;
      eaddr = epend ? 8'(32'(epidx) * 3) : eaddr + 8'd1;
      epend = 0;
    end else eaddr = eaddr + 8'd1;
    eslot = (eslot + 1) % 3;
    #2;
    redirect = 0;
    check(mem_addr == eaddr, atag, 32'(mem_addr), 32'(eaddr));
    check(instr_valid == ev, "R4", 32'(instr_valid), 32'(ev));
    check(instr_word == eword, ev ? "R3/R5" : "R4 hold", 32'(instr_word), 32'(eword));
  endtask

  task automatic align();
    while (eslot != 0) tick(0, 0, "R2");
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    #2;
    check(mem_addr == 0, "R1", 32'(mem_addr), 0);
    check(instr_valid == 0, "R1", 32'(instr_valid), 0);
    check(instr_word == 0, "R1", 32'(instr_word), 0);
    #3 rst_n = 1;

    for (int i = 0; i < 12; i++) tick(0, 0, "R2");

    tick(1, 7'd10, "R6");
    tick(0, 0, "R6");
    tick(0, 0, "R6");
    tick(0, 0, "R6");

    align();
    tick(1, 7'd5, "R7");
    tick(1, 7'd9, "R7");
    tick(0, 0, "R7");
    check(mem_addr == 8'd27, "R7", 32'(mem_addr), 27);

    align();
    tick(0, 0, "R8");
    tick(0, 0, "R8");
    tick(1, 7'd84, "R8");
    for (int i = 0; i < 6; i++) tick(0, 0, "R8");

    align();
    tick(0, 0, "R6");
    tick(0, 0, "R6");
    tick(1, 7'd127, "R6");
    check(mem_addr == 8'd125, "R6", 32'(mem_addr), 125);

    for (int i = 0; i < 4000; i++)
      tick(($urandom % 8) == 0, 7'($urandom), "R2");

    @(posedge clk); #2;
    rst_n = 0;
    #1;
    check(mem_addr == 0, "R1", 32'(mem_addr), 0);
    check(instr_valid == 0, "R1", 32'(instr_valid), 0);
    check(instr_word == 0, "R1", 32'(instr_word), 0);
    model_reset();
    @(posedge clk); #5 rst_n = 1;
    for (int i = 0; i < 9; i++) tick(0, 0, "R1");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule